// File: doc/BRIEF.md
# Decimal Accumulator Processor Core

This block is a small stored-program processor. It has one accumulator and works on three-digit decimal words (000 to 999). Instructions and data share a single 100-word memory that lives outside the block. The core reaches that memory only through its address register (driven out on `mem_addr`) and its data register (driven out on `mem_wdata` for writes and loaded from `mem_rdata` on reads). The memory read path is combinational: `mem_rdata` must show the word at `mem_addr` in the same cycle.

Each instruction is one decimal word. The hundreds digit is the operation code and the remaining two digits are a memory address. Every instruction starts with the same three-cycle fetch: the program counter moves into the address register, the memory word is captured into the data register, and that word is copied into the instruction register. A fixed per-opcode sequence of register-transfer steps follows. Values are brought in through an input port with a valid/ready handshake and sent out through a registered output with a one-cycle strobe. A halted status shows that execution has stopped for good until the next reset.

Top module: `dacc_cpu`

## Requirements
- R1: After synchronous reset the program counter, accumulator and negative flag are zero, `halted`, `out_valid`, `mem_we` and `in_ready` are low, and `mem_addr` is 00. The first instruction is fetched from address 00.
- R2: Counting clock edges from the release of reset, each instruction takes a fixed number of cycles, and the first three of them are the fetch. Load (5), add (1) and subtract (2) take 6 cycles. Store (3) takes 5. Branches, output, an input whose data is already valid, and the decode of a halt take 4.
- R3: Load `5aa` sets the accumulator to word `aa`. Add `1aa` sets it to (accumulator + word `aa`) mod 1000. Subtract `2aa` sets it to (accumulator − word `aa`) mod 1000. Each then advances the program counter by one.
- R4: A subtraction that underflows (operand greater than accumulator) sets the negative flag. A subtraction that does not underflow leaves the flag as it was. Load, add and input clear the flag.
- R5: Store `3aa` raises `mem_we` for exactly one cycle, with `mem_addr` = `aa` and `mem_wdata` = accumulator. No other instruction writes memory.
- R6: Opcode 6 always loads the address field into the program counter. Opcode 7 does so only when the accumulator is 000. Opcode 8 does so only when the negative flag is clear. A conditional branch that is not taken advances the program counter by one.
- R7: Instruction `901` holds `in_ready` high and makes no progress until `in_valid` is high. In that cycle it loads `in_data` (0 to 999) into the accumulator.
- R8: Instruction `902` copies the accumulator to `out_data` and pulses `out_valid` high for exactly one cycle. `out_data` changes at no other time.
- R9: Opcode 0, opcode 4, and opcode 9 with any address other than 01 or 02 halt the core. `halted` then stays high, and no memory write, output strobe or input request follows.
- R10: The program counter wraps from 99 to 00 when advanced by one, and `mem_addr` never leaves the range 00 to 99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 7 | Address register contents, word address 0..99 |
| mem_rdata | input | 10 | Word read combinationally at `mem_addr` |
| mem_wdata | output | 10 | Data register contents, the word to write |
| mem_we | output | 1 | Write strobe for the word at `mem_addr` |
| in_valid | input | 1 | Input word is available |
| in_ready | output | 1 | Core is waiting in an input instruction |
| in_data | input | 10 | Input word, 0..999 |
| out_valid | output | 1 | One-cycle strobe when `out_data` is updated |
| out_data | output | 10 | Output register |
| halted | output | 1 | Core has stopped executing |

## Verification
The bench aims at these corner cases:
- Subtraction underflow followed by a non-negative branch. A core that cleared or ignored the flag in the wrong place would take that branch.
- A subtraction that does not underflow while the flag is already set. A core that rewrote the flag on every subtraction would end up on the wrong path.
- A program that runs through address 99 back to 00. A core without the wrap would fetch from an address outside memory.
- An input instruction held for many cycles without valid data. A core that did not stall would load a stale or wrong value, and the total cycle count would be off.
- Every halt encoding: opcodes 0 and 4, and opcode 9 with a foreign address. A core that decoded these as input or output would keep running or emit strobes after it should have stopped.

Random straight-line programs with forward branches compare the output stream, the final memory image and the exact cycle count against an instruction-level model in the bench. A wrong micro-step count therefore shows up even when the data comes out right.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

    // Operation digits (hundreds digit of an instruction word)
    localparam logic [3:0] OP_HLT = 4'd0;
    localparam logic [3:0] OP_ADD = 4'd1;
    localparam logic [3:0] OP_SUB = 4'd2;
    localparam logic [3:0] OP_STA = 4'd3;
    localparam logic [3:0] OP_LDA = 4'd5;
    localparam logic [3:0] OP_BRA = 4'd6;
    localparam logic [3:0] OP_BRZ = 4'd7;
    localparam logic [3:0] OP_BRP = 4'd8;
    localparam logic [3:0] OP_IO  = 4'd9;

    // Address-field selectors for the I/O opcode
    localparam int unsigned IO_IN_SEL  = 1;
    localparam int unsigned IO_OUT_SEL = 2;

    typedef enum logic [2:0] {
        ST_FADR = 3'd0,  // PC -> MAR
        ST_FRD  = 3'd1,  // mem -> MDR
        ST_DEC  = 3'd2,  // MDR -> IR
        ST_EXE  = 3'd3,  // dispatch on IR
        ST_ORD  = 3'd4,  // operand mem -> MDR
        ST_ALU  = 3'd5,  // accumulator update
        ST_STW  = 3'd6,  // MDR -> mem
        ST_HALT = 3'd7
    } step_e;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'd0,
        ALU_SUB  = 2'd1,
        ALU_PASS = 2'd2
    } alu_op_e;

endpackage

// File: rtl/dacc_alu.sv
module dacc_alu
    import dacc_pkg::*;
#(
    parameter int unsigned WORD_W  = 10,
    parameter int unsigned MODULUS = 1000
) (
    input  alu_op_e           op,
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] opnd,
    output logic [WORD_W-1:0] res,
    output logic              borrow
);
    localparam logic [WORD_W:0] MOD_X = (WORD_W + 1)'(MODULUS);

    logic [WORD_W:0] sum_x;
    logic [WORD_W:0] dif_x;

    always_comb begin
        sum_x  = {1'b0, acc} + {1'b0, opnd};
        dif_x  = {1'b0, acc} + MOD_X - {1'b0, opnd};
        res    = opnd;
        borrow = 1'b0;
        case (op)
            ALU_ADD: begin
                res = (sum_x >= MOD_X) ? WORD_W'(sum_x - MOD_X) : WORD_W'(sum_x);
            end
            ALU_SUB: begin
                borrow = (opnd > acc);
                res    = (dif_x >= MOD_X) ? WORD_W'(dif_x - MOD_X) : WORD_W'(dif_x);
            end
            default: res = opnd;
        endcase
    end

endmodule

// File: rtl/dacc_split.sv
module dacc_split #(
    parameter int unsigned WORD_W = 10,
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned WORDS  = 100
) (
    input  logic [WORD_W-1:0] word,
    output logic [3:0]        op,
    output logic [ADDR_W-1:0] fld
);
    localparam logic [WORD_W-1:0] BASE = WORD_W'(WORDS);

    always_comb begin
        op  = 4'(word / BASE);
        fld = ADDR_W'(word % BASE);
    end

endmodule

// File: rtl/dacc_cpu.sv
module dacc_cpu
    import dacc_pkg::*;
#(
    parameter int unsigned WORDS   = 100,
    parameter int unsigned ADDR_W  = 7,
    parameter int unsigned WORD_W  = 10,
    parameter int unsigned MODULUS = 1000
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              halted
);
    localparam logic [ADDR_W-1:0] LAST_PC = ADDR_W'(WORDS - 1);
    localparam logic [ADDR_W-1:0] SEL_IN  = ADDR_W'(IO_IN_SEL);
    localparam logic [ADDR_W-1:0] SEL_OUT = ADDR_W'(IO_OUT_SEL);

    typedef struct packed {
        step_e             step;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [WORD_W-1:0] mdr;
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] acc;
        logic              neg;
        logic [WORD_W-1:0] outr;
        logic              outv;
    } core_t;

    core_t core_d, core_q;

    logic [3:0]        ir_op;
    logic [ADDR_W-1:0] ir_fld;
    alu_op_e           alu_sel;
    logic [WORD_W-1:0] alu_res;
    logic              alu_borrow;
    logic [ADDR_W-1:0] pc_inc;
    logic              ready_c;
    logic              we_c;

    dacc_split #(
        .WORD_W(WORD_W),
        .ADDR_W(ADDR_W),
        .WORDS (WORDS)
    ) u_split (
        .word(core_q.ir),
        .op  (ir_op),
        .fld (ir_fld)
    );

    always_comb begin
        case (ir_op)
            OP_ADD:  alu_sel = ALU_ADD;
            OP_SUB:  alu_sel = ALU_SUB;
            default: alu_sel = ALU_PASS;
        endcase
    end

    dacc_alu #(
        .WORD_W (WORD_W),
        .MODULUS(MODULUS)
    ) u_alu (
        .op    (alu_sel),
        .acc   (core_q.acc),
        .opnd  (core_q.mdr),
        .res   (alu_res),
        .borrow(alu_borrow)
    );

    assign pc_inc = (core_q.pc == LAST_PC) ? '0 : core_q.pc + 1'b1;

    always_comb begin
        core_d      = core_q;
        core_d.outv = 1'b0;
        ready_c     = 1'b0;
        we_c        = 1'b0;
        case (core_q.step)
            ST_FADR: begin
                core_d.mar  = core_q.pc;
                core_d.step = ST_FRD;
            end
            ST_FRD: begin
                core_d.mdr  = mem_rdata;
                core_d.step = ST_DEC;
            end
            ST_DEC: begin
                core_d.ir   = core_q.mdr;
                core_d.step = ST_EXE;
            end
            ST_EXE: begin
                core_d.step = ST_FADR;
                case (ir_op)
                    OP_ADD, OP_SUB, OP_LDA: begin
                        core_d.mar  = ir_fld;
                        core_d.step = ST_ORD;
                    end
                    OP_STA: begin
                        core_d.mar  = ir_fld;
                        core_d.mdr  = core_q.acc;
                        core_d.step = ST_STW;
                    end
                    OP_BRA: core_d.pc = ir_fld;
                    OP_BRZ: core_d.pc = (core_q.acc == '0) ? ir_fld : pc_inc;
                    OP_BRP: core_d.pc = core_q.neg ? pc_inc : ir_fld;
                    OP_IO: begin
                        if (ir_fld == SEL_IN) begin
                            ready_c = 1'b1;
                            if (in_valid) begin
                                core_d.acc = in_data;
                                core_d.neg = 1'b0;
                                core_d.pc  = pc_inc;
                            end else begin
                                core_d.step = ST_EXE;
                            end
                        end else if (ir_fld == SEL_OUT) begin
                            core_d.outr = core_q.acc;
                            core_d.outv = 1'b1;
                            core_d.pc   = pc_inc;
                        end else begin
                            core_d.step = ST_HALT;
                        end
                    end
                    default: core_d.step = ST_HALT;
                endcase
            end
            ST_ORD: begin
                core_d.mdr  = mem_rdata;
                core_d.step = ST_ALU;
            end
            ST_ALU: begin
                core_d.acc = alu_res;
                if (ir_op == OP_SUB) begin
                    if (alu_borrow) core_d.neg = 1'b1;
                end else begin
                    core_d.neg = 1'b0;
                end
                core_d.pc   = pc_inc;
                core_d.step = ST_FADR;
            end
            ST_STW: begin
                we_c        = 1'b1;
                core_d.pc   = pc_inc;
                core_d.step = ST_FADR;
            end
            default: core_d.step = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign mem_addr  = core_q.mar;
    assign mem_wdata = core_q.mdr;
    assign mem_we    = we_c;
    assign in_ready  = ready_c;
    assign out_valid = core_q.outv;
    assign out_data  = core_q.outr;
    assign halted    = (core_q.step == ST_HALT);

endmodule

// File: rtl/dacc_cpu_chk.sv
module dacc_cpu_chk #(
    parameter int unsigned WORDS  = 100,
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned WORD_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data,
    input logic              halted
);
    localparam logic [ADDR_W-1:0] ADDR_LIM = ADDR_W'(WORDS);

    // R1: quiet outputs and address 00 right after a reset cycle
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (mem_addr == '0 && !halted && !out_valid && !mem_we && !in_ready));

    // R5: a write strobe never lasts two cycles
    p_we_single_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R8: the output strobe is one cycle wide
    p_out_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R8: output register only moves together with its strobe
    p_out_stable_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    // R7: waiting for input holds the request and the address
    p_in_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> (in_ready && $stable(mem_addr)));

    // R9: halt is sticky
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R9: nothing happens once halted
    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_we && !out_valid && !in_ready));

    // R10: address stays inside memory
    p_addr_range_r10: assert property (@(posedge clk) disable iff (rst)
        mem_addr < ADDR_LIM);

endmodule

bind dacc_cpu dacc_cpu_chk #(
    .WORDS (WORDS),
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_we   (mem_we),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .halted   (halted)
);

// File: tb/dacc_cpu_test.sv
module dacc_cpu_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] mem_addr;
    logic [9:0] mem_rdata;
    logic [9:0] mem_wdata;
    logic       mem_we;
    logic       in_valid;
    logic       in_ready;
    logic [9:0] in_data;
    logic       out_valid;
    logic [9:0] out_data;
    logic       halted;

    always #10 clk = ~clk;  // 50 MHz

    int n_cmp = 0;
    int n_bad = 0;

    logic [9:0] mem    [100];
    logic [9:0] prog   [100];
    logic [9:0] expm   [100];
    logic [9:0] in_seq [32];
    logic [9:0] got_out[64];
    logic [9:0] exp_out[64];
    int   got_n;
    int   exp_n;
    int   in_idx;
    bit   take_pend;
    bit   hold_valid;

    assign mem_rdata = (mem_addr < 7'd100) ? mem[mem_addr] : 10'd0;
    assign in_valid  = !hold_valid;
    assign in_data   = in_seq[in_idx];

    dacc_cpu uut (
        .clk(clk), .rst(rst),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data),
        .halted(halted)
    );

    always @(posedge clk) begin
        if (mem_we && mem_addr < 7'd100) mem[mem_addr] <= mem_wdata;
    end

    always @(negedge clk) begin
        if (take_pend) in_idx = in_idx + 1;
        take_pend = in_ready && in_valid && !rst;
        if (out_valid && !rst && got_n < 64) begin
            got_out[got_n] = out_data;
            got_n = got_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Instruction-level model: fills expm, exp_out, returns cycle count
    task automatic iss_run(output int cyc);
        int pc = 0, acc = 0, steps = 0, ii = 0;
        bit neg = 0;
        cyc = 0;
        exp_n = 0;
        for (int i = 0; i < 100; i++) expm[i] = prog[i];
        while (steps < 5000) begin
            int w  = int'(expm[pc]);
            int op = w / 100;
            int a  = w % 100;
            int m  = int'(expm[a]);
            int nx = (pc == 99) ? 0 : pc + 1;
            bit stop = 0;
            steps++;
            case (op)
                1: begin acc = (acc + m) % 1000; neg = 0; cyc += 6; pc = nx; end
                2: begin
                    if (m > acc) begin acc = acc + 1000 - m; neg = 1; end
                    else acc = acc - m;
                    cyc += 6; pc = nx;
                end
                3: begin expm[a] = 10'(acc); cyc += 5; pc = nx; end
                5: begin acc = m; neg = 0; cyc += 6; pc = nx; end
                6: begin pc = a; cyc += 4; end
                7: begin pc = (acc == 0) ? a : nx; cyc += 4; end
                8: begin pc = neg ? nx : a; cyc += 4; end
                9: begin
                    if (a == 1) begin acc = int'(in_seq[ii]); ii++; neg = 0; cyc += 4; pc = nx; end
                    else if (a == 2) begin exp_out[exp_n] = 10'(acc); exp_n++; cyc += 4; pc = nx; end
                    else begin cyc += 4; stop = 1; end
                end
                default: begin cyc += 4; stop = 1; end
            endcase
            if (stop) break;
        end
    endtask

    task automatic run_prog(input string name, input int stall);
        int exp_cyc, cyc = 0;
        bit mem_ok = 1, out_ok = 1, quiet = 1;
        iss_run(exp_cyc);
        exp_cyc += stall;
        @(negedge clk);
        rst = 1'b1;
        hold_valid = (stall > 0);
        for (int i = 0; i < 100; i++) mem[i] = prog[i];
        @(negedge clk);
        @(negedge clk);
        in_idx = 0; take_pend = 0; got_n = 0;
        rst = 1'b0;
        while (cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (stall > 0 && cyc == 3 + stall) begin
                // R7: still waiting for input after the stall
                check(in_ready == 1'b1, "R7 stall ready", int'(in_ready), 1);
                check(mem_addr == 7'd0, "R7 stall address held", int'(mem_addr), 0);
                hold_valid = 1'b0;
            end
            if (halted) break;
        end
        $display("program %s: %0d cycles", name, cyc);
        check(halted == 1'b1, "R9 halted reached", int'(halted), 1);
        check(cyc == exp_cyc, "R2 cycle count", cyc, exp_cyc);
        check(got_n == exp_n, "R8 output count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            if (got_out[i] !== exp_out[i]) begin
                out_ok = 0;
                check(0, "R3 R8 output value", int'(got_out[i]), int'(exp_out[i]));
            end
        end
        if (out_ok) check(1, "R3 R8 output value", 0, 0);
        for (int i = 0; i < 100; i++) begin
            if (mem[i] !== expm[i]) begin
                mem_ok = 0;
                check(0, "R5 memory image", int'(mem[i]), int'(expm[i]));
            end
        end
        if (mem_ok) check(1, "R5 memory image", 0, 0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (!halted || mem_we || out_valid || in_ready) quiet = 0;
        end
        check(quiet, "R9 stays halted and quiet", int'(quiet), 1);
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 100; i++) prog[i] = 10'd0;
    endtask

    task automatic gen_random();
        int len = 8 + int'($urandom % 20);
        clear_prog();
        for (int i = 60; i < 100; i++)
            prog[i] = (($urandom % 5) == 0) ? 10'd0 : 10'($urandom % 1000);
        for (int i = 0; i < len; i++) begin
            int k   = int'($urandom % 10);
            int dat = 60 + int'($urandom % 40);
            int tgt = i + 1 + int'($urandom % (len - i));
            case (k)
                0: prog[i] = 10'(500 + dat);
                1: prog[i] = 10'(100 + dat);
                2: prog[i] = 10'(200 + dat);
                3: prog[i] = 10'(300 + dat);
                4: prog[i] = 10'd901;
                6: prog[i] = 10'(600 + tgt);
                7: prog[i] = 10'(700 + tgt);
                8: prog[i] = 10'(800 + tgt);
                default: prog[i] = 10'd902;
            endcase
        end
        case ($urandom % 3)
            0: prog[len] = 10'(int'($urandom % 100));
            1: prog[len] = 10'(400 + int'($urandom % 100));
            default: prog[len] = 10'(903 + int'($urandom % 97));
        endcase
    endtask

    initial begin
        #(20ns * 190000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        hold_valid = 1'b0;
        take_pend = 0; in_idx = 0; got_n = 0;
        for (int i = 0; i < 32; i++) in_seq[i] = 10'($urandom % 1000);
        for (int i = 0; i < 100; i++) mem[i] = 10'd0;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check(mem_addr == 7'd0, "R1 reset address", int'(mem_addr), 0);
        check(!halted, "R1 reset halted", int'(halted), 0);
        check(!out_valid, "R1 reset out_valid", int'(out_valid), 0);
        check(!mem_we, "R1 reset mem_we", int'(mem_we), 0);
        check(!in_ready, "R1 reset in_ready", int'(in_ready), 0);

        // R10 R6: run through 99 back to 00, zero branch taken then not
        clear_prog();
        prog[0] = 10'd710; prog[1] = 10'd0; prog[10] = 10'd698;
        prog[98] = 10'd500; prog[99] = 10'd902;
        run_prog("wrap R10", 0);
        check(exp_n == 1 && exp_out[0] == 10'd710, "R10 model wrap output", int'(exp_out[0]), 710);

        // R4 R6: underflow flag, no-underflow subtract keeps flag, add clears it
        clear_prog();
        prog[0] = 10'd560; prog[1] = 10'd261; prog[2] = 10'd902; prog[3] = 10'd811;
        prog[4] = 10'd262; prog[5] = 10'd811; prog[6] = 10'd162; prog[7] = 10'd811;
        prog[8] = 10'd902; prog[9] = 10'd0;   prog[11] = 10'd902; prog[12] = 10'd363;
        prog[13] = 10'd400;
        prog[60] = 10'd5; prog[61] = 10'd7; prog[62] = 10'd0;
        run_prog("flag R4", 0);
        check(got_n == 2 && got_out[0] == 10'd998, "R4 underflow value", int'(got_out[0]), 998);
        check(mem[63] == 10'd998, "R4 R5 stored after add", int'(mem[63]), 998);

        // R7: input stalled for 15 cycles
        clear_prog();
        prog[0] = 10'd901; prog[1] = 10'd902; prog[2] = 10'd950;
        run_prog("stall R7", 15);
        check(got_out[0] == in_seq[0], "R7 input value", int'(got_out[0]), int'(in_seq[0]));

        // R3 R6 R9: random programs with forward branches
        for (int p = 0; p < 40; p++) begin
            gen_random();
            run_prog($sformatf("rand%0d", p), 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule